// File: doc/BRIEF.md
# SPI Variable-Length Shift Datapath

This block is the serial core of an SPI port. It takes a 32-bit word from the transmit side and puts one frame of 8, 16, 24 or 32 bits on the serial output pin. That pin is MOSI when the port is a master and MISO when it is a slave, and the serial input is the other pin. Over the same frame it collects the bits that arrive on the serial input into the same register. When the frame ends it produces a 32-bit receive word and pulses a valid strobe.

The bit order is selectable. In least-significant-first mode the active bits are reversed when the word is loaded. The shift register itself always moves in one direction and always sends its top bit. When the frame is shorter than the word, each incoming bit enters at an interior register position, `W` minus the frame length. The register bits below that position hold the unused upper bits of the transmit word, and they pass unchanged into the upper bits of the receive word.

An external clock generator supplies two enables. `sample_en` marks the serial-clock edge on which the input is sampled. `shift_en` marks the edge on which the register advances and the output changes. Clock generation, chip select and parity are handled outside this block.

Top module: `spi_shift_dp`

## Requirements
- R1: After reset, `rx_word` is 0, `rx_valid` is 0 and `sout` is 0.
- R2: The length code `len_sel` selects the frame length L: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. A frame uses exactly L `shift_en` pulses. `rx_valid` is high for exactly one clock, and it is visible right after the clock edge that applies the L-th `shift_en`.
- R3: With `lsb_first`=0, `sout` shows `tx_word[L-1]` right after the load edge. After the k-th shift it shows `tx_word[L-1-k]`.
- R4: With `lsb_first`=1, `sout` shows `tx_word[0]` right after the load edge. After the k-th shift it shows `tx_word[k]`.
- R5: With `lsb_first`=0, the k-th received bit of a frame (k=0 first) appears at `rx_word[L-1-k]`.
- R6: With `lsb_first`=1, the k-th received bit appears at `rx_word[k]`.
- R7: When L is less than 32, `rx_word[31:L]` equals `tx_word[31:L]` of the word that started the frame.
- R8: A `tx_load` while a frame is in progress has no effect on `sout`, on `rx_word` or on the frame.
- R9: The received bit for a shift is the `sin` value captured at the latest `sample_en`. If `sample_en` and `shift_en` occur in the same cycle, the `sin` of that cycle is used.
- R10: `len_sel` and `lsb_first` are captured at load. Changing them during a frame does not alter that frame.
- R11: `shift_en` pulses while no frame is in progress produce no `rx_valid` and do not change `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_word | input | 32 | Word from the transmit buffer |
| tx_load | input | 1 | Load strobe; starts a frame when idle |
| len_sel | input | 2 | Frame length code (8/16/24/32) |
| lsb_first | input | 1 | 1: least significant bit first |
| sample_en | input | 1 | Serial-clock edge that samples `sin` |
| shift_en | input | 1 | Serial-clock edge that advances the register |
| sin | input | 1 | Serial input (MISO as master, MOSI as slave) |
| sout | output | 1 | Serial output (MOSI as master, MISO as slave) |
| rx_word | output | 32 | Assembled receive word |
| rx_valid | output | 1 | One-clock strobe when `rx_word` updates |

## Verification
Every length code is exercised with both bit orders. The transmit and receive patterns used are all ones, alternating bits, a single walking one and a pseudo-random word.

- The walking one and the random words expose any mix-up in bit position or order, both on `sout` and in `rx_word`.
- All ones and alternating bits, paired with different upper transmit bytes, separate the pass-through upper field from the received field.
- Some frames also carry a stray load and a configuration change mid-frame, which show whether the stored frame is disturbed.
- Other frames sample and shift in the same cycle, which checks that `sin` is taken directly in that case.
- Idle shift pulses between frames check that nothing is produced without a load.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;
  // Frame length codes; frame length is (code + 1) quarters of the word.
  typedef enum logic [1:0] {
    LEN_Q1   = 2'd0,
    LEN_Q2   = 2'd1,
    LEN_Q3   = 2'd2,
    LEN_FULL = 2'd3
  } len_code_e;

  typedef struct packed {
    len_code_e len;
    logic      lsb_first;
  } frame_cfg_t;
endpackage

// File: rtl/spi_bit_count.sv
module spi_bit_count #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [LW-1:0] frame_len,
  output logic          busy,
  output logic          last
);
  logic [LW-1:0] cnt_q;

  assign last = busy && step && (cnt_q == frame_len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (last) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy && step) begin
      cnt_q <= cnt_q + LW'(1);
    end
  end

  // The count never reaches the frame length (R2)
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < frame_len));

  // Completing a frame always returns to idle (R2)
  assert_done_goes_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic          shift,
  input  logic          ins_bit,
  input  logic [PW-1:0] ins_pos,
  output logic [W-1:0]  sreg,
  output logic [W-1:0]  sreg_nxt
);
  logic [W-1:0] shifted;
  logic [W-1:0] hold_mask;

  // Bits below the insertion point keep their value; the point takes the
  // new bit; everything above moves one place up.
  genvar j;
  generate
    for (j = 0; j < W; j++) begin : g_bit
      if (j == 0) begin : g_bottom
        assign shifted[j]   = (ins_pos == PW'(0)) ? ins_bit : sreg[j];
        assign hold_mask[j] = (ins_pos != PW'(0));
      end else begin : g_upper
        assign shifted[j]   = (PW'(j) > ins_pos)  ? sreg[j-1] :
                              (PW'(j) == ins_pos) ? ins_bit   : sreg[j];
        assign hold_mask[j] = (PW'(j) < ins_pos);
      end
    end
  endgenerate

  assign sreg_nxt = load ? load_word : (shift ? shifted : sreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '0;
    else        sreg <= sreg_nxt;
  end

  // Pass-through field below the insertion point is untouched by shifting (R7)
  assert_low_field_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (((sreg ^ $past(sreg)) & $past(hold_mask)) == '0));

  // The inserted bit lands at the insertion position (R9)
  assert_insert_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (sreg[$past(ins_pos)] == $past(ins_bit)));
endmodule

// File: rtl/spi_rx_build.sv
module spi_rx_build #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [W-1:0]  raw,
  input  logic [LW-1:0] frame_len,
  input  logic          lsb_first,
  output logic [W-1:0]  rx_word,
  output logic          rx_valid
);
  // Unscramble the finished shift register into natural bit order.
  function automatic logic [W-1:0] rx_map(input logic [W-1:0] r,
                                          input int len, input logic lsb);
    logic [W-1:0] o;
    o = '0;
    for (int i = 0; i < W; i++) begin
      if (i < len) o[i] = lsb ? r[W-1-i] : r[W-len+i];
      else         o[i] = r[i-len];
    end
    return o;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= capture;
      if (capture) rx_word <= rx_map(raw, int'(frame_len), lsb_first);
    end
  end

  // Valid is a single-clock pulse (R2)
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // Receive word only moves when a frame completes (R11)
  assert_rx_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rx_word));
endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_dp_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1),
  parameter int PW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_word,
  input  logic         tx_load,
  input  logic [1:0]   len_sel,
  input  logic         lsb_first,
  input  logic         sample_en,
  input  logic         shift_en,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] rx_word,
  output logic         rx_valid
);
  localparam int QW = W / 4;

  function automatic logic [LW-1:0] len_of(input len_code_e c);
    return LW'((int'(c) + 1) * QW);
  endfunction

  // Active bits go to the top of the register (reversed if LSB first);
  // unused upper bits of the word fill the bottom.
  function automatic logic [W-1:0] load_map(input logic [W-1:0] t,
                                            input int len, input logic lsb);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < W; i++) begin
      if (i < len) begin
        if (lsb) m[W-1-i]     = t[i];
        else     m[W-len+i]   = t[i];
      end else begin
        m[i-len] = t[i];
      end
    end
    return m;
  endfunction

  frame_cfg_t    cfg_in, cfg_q;
  logic          busy, frame_done, load_ok, shift_ok, ins_bit, samp_q;
  logic [LW-1:0] len_q;
  logic [PW-1:0] ins_pos;
  logic [W-1:0]  load_word, sreg, sreg_nxt;

  assign cfg_in    = '{len: len_code_e'(len_sel), lsb_first: lsb_first};
  assign load_ok   = tx_load && !busy;
  assign shift_ok  = shift_en && busy;
  assign len_q     = len_of(cfg_q.len);
  assign ins_pos   = PW'(W - int'(len_q));
  assign ins_bit   = sample_en ? sin : samp_q;
  assign load_word = load_map(tx_word, int'(len_of(cfg_in.len)), cfg_in.lsb_first);
  assign sout      = sreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{len: LEN_FULL, lsb_first: 1'b0};
      samp_q <= 1'b0;
    end else begin
      if (load_ok)   cfg_q  <= cfg_in;
      if (sample_en) samp_q <= sin;
    end
  end

  spi_bit_count #(.W(W), .LW(LW)) u_count (
    .clk(clk), .rst_n(rst_n), .start(load_ok), .step(shift_ok),
    .frame_len(len_q), .busy(busy), .last(frame_done)
  );

  spi_shift_core #(.W(W), .PW(PW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_word(load_word),
    .shift(shift_ok), .ins_bit(ins_bit), .ins_pos(ins_pos),
    .sreg(sreg), .sreg_nxt(sreg_nxt)
  );

  spi_rx_build #(.W(W), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .capture(frame_done), .raw(sreg_nxt),
    .frame_len(len_q), .lsb_first(cfg_q.lsb_first),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  // A load during a frame leaves the register alone (R8)
  assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_load && !shift_en) |=> $stable(sreg));

  // Configuration is frozen for the whole frame (R10)
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> $stable(cfg_q));

  // Valid only follows a completed frame (R11)
  assert_valid_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(frame_done));
endmodule

// File: tb/tb_spi_shift_dp.sv
module tb_spi_shift_dp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tx_word = '0;
  logic        tx_load = 1'b0;
  logic [1:0]  len_sel = '0;
  logic        lsb_first = 1'b0;
  logic        sample_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        sin = 1'b0;
  logic        sout;
  logic [31:0] rx_word;
  logic        rx_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  spi_shift_dp dut (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_load(tx_load),
    .len_sel(len_sel), .lsb_first(lsb_first), .sample_en(sample_en),
    .shift_en(shift_en), .sin(sin), .sout(sout), .rx_word(rx_word),
    .rx_valid(rx_valid)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected receive word computed from the requirements.
  function automatic logic [31:0] exp_rx(input logic [31:0] t, input logic [31:0] s,
                                         input int len, input bit lsb);
    logic [31:0] e;
    e = t;                                           // R7 upper field
    for (int k = 0; k < len; k++) begin
      if (lsb) e[k] = s[k];                          // R6
      else     e[len-1-k] = s[k];                    // R5
    end
    return e;
  endfunction

  function automatic bit exp_out(input logic [31:0] t, input int len,
                                 input bit lsb, input int k);
    return lsb ? t[k] : t[len-1-k];                  // R4 / R3
  endfunction

  // variant bit0: stray load + config change mid-frame; bit1: same-cycle sample/shift
  task automatic run_frame(input logic [31:0] t, input logic [31:0] s,
                           input int code, input bit lsb, input int variant);
    int len;
    string rq;
    len = (code + 1) * 8;
    rq  = lsb ? "R4" : "R3";
    @(negedge clk);
    tx_word = t; len_sel = 2'(code); lsb_first = lsb; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    check(rq, 32'(sout), 32'(exp_out(t, len, lsb, 0)));
    for (int k = 0; k < len; k++) begin
      if (variant[0] && k == 2) begin
        tx_word = ~t; tx_load = 1'b1; len_sel = 2'(3 - code); lsb_first = !lsb;
        @(negedge clk);
        tx_load = 1'b0;
        check("R8", 32'(sout), 32'(exp_out(t, len, lsb, k)));
      end
      if (variant[1]) begin
        sin = s[k]; sample_en = 1'b1; shift_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0; shift_en = 1'b0;
      end else begin
        sin = s[k]; sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0; sin = !s[k]; shift_en = 1'b1;  // R9: sin changes after sampling
        @(negedge clk);
        shift_en = 1'b0;
      end
      if (k < len - 1) begin
        check(rq, 32'(sout), 32'(exp_out(t, len, lsb, k + 1)));
        check("R2", 32'(rx_valid), 32'd0);
      end
    end
    check("R2", 32'(rx_valid), 32'd1);
    check(lsb ? "R6" : "R5", rx_word, exp_rx(t, s, len, lsb));
    if (variant[0]) check("R10", rx_word, exp_rx(t, s, len, lsb));
    if (variant[1]) check("R9", rx_word, exp_rx(t, s, len, lsb));
    @(negedge clk);
    check("R2", 32'(rx_valid), 32'd0);
    len_sel = 2'(code); lsb_first = lsb;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr, t, s, last_rx;
    lfsr = 32'h1ACE_5EED;
    repeat (3) @(negedge clk);
    check("R1", rx_word, 32'd0);
    check("R1", 32'(rx_valid), 32'd0);
    check("R1", 32'(sout), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int code = 0; code < 4; code++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        for (int p = 0; p < 5; p++) begin
          case (p)
            0: begin t = 32'hFFFF_FFFF; s = 32'hFFFF_FFFF; end
            1: begin t = 32'hAAAA_5555; s = 32'h5555_AAAA; end
            2: begin t = 32'h0000_0001 << (code * 8 + 3); s = 32'h1 << (code * 5 + 2); end
            3: begin t = 32'h00C3_81F0; s = 32'h0000_0000; end
            default: begin
              for (int r = 0; r < 17; r++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
              t = lfsr;
              for (int r = 0; r < 13; r++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
              s = lfsr;
            end
          endcase
          run_frame(t, s, code, lsb[0], (p == 4) ? 1 : ((p == 1) ? 2 : 0));
        end
        // R11: idle shift/sample pulses do nothing
        last_rx = rx_word;
        repeat (3) begin
          sin = 1'b1; sample_en = 1'b1; shift_en = 1'b1;
          @(negedge clk);
          sample_en = 1'b0; shift_en = 1'b0;
          check("R11", 32'(rx_valid), 32'd0);
        end
        @(negedge clk);
        check("R11", rx_word, last_rx);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule